// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a bus slave that behaves like a byte-wide serial EEPROM on a two-wire (I2C-style) bus. It samples the clock and data lines with the system clock and finds START and STOP conditions. It accepts a select byte that carries three strap bits and a direction bit. A write transfer then carries a two-byte word address, high byte first, and any number of data bytes. A read transfer returns bytes from an internal address pointer for as long as the master acknowledges them. The data line is never driven high: the block only raises a pull-low enable, which the pad turns into an open-drain output.

Data bytes of a write are collected in a 64-entry page buffer. They reach the array only after the STOP that closes the transfer. The array copy happens inside a self-timed busy period of `WR_CYCLES` clock cycles. During that period the block answers no select byte. A write-protect input that is high at that STOP discards the whole buffered write. The array depth is a parameter, `MEM_AW` address bits, at most 15. The default of 11 bits keeps the model small. Word-address bits above the array depth are ignored.

Top module: `eep2w_slave`

## Requirements
- R1: After reset the pull-low enable is inactive, no write cycle is running, and the first matching select byte is acknowledged.
- R2: A select byte is acknowledged only if its upper seven bits (sent first) equal 1010 followed by strap bits 2, 1, 0; bit 0 is the direction (0 write, 1 read). After a mismatch the block acknowledges nothing until the next START.
- R3: The word address is two bytes, high byte first. Bit 7 of the high byte, and every bit at or above MEM_AW, is ignored (default MEM_AW = 11, so address 0xF940 names byte 0x140).
- R4: In a write, every address and data byte is acknowledged. After the closing STOP the buffered bytes are written to the array.
- R5: A STOP that ends a write with at least one data byte, while write-protect is low, starts a busy period of WR_CYCLES clock cycles. During that period no select byte is acknowledged. Afterwards select bytes are acknowledged again.
- R6: Within one write, the low six address bits step after each data byte and wrap inside the 64-byte page. A later byte for the same offset replaces the earlier one.
- R7: If write-protect is high at the closing STOP, all bytes are still acknowledged, the array is unchanged, and no busy period follows.
- R8: Random read: a write transfer that carries only the word address, then a repeated START and a read select, returns the byte stored at that address.
- R9: A read select with no preceding address returns the byte that follows the last byte read.
- R10: During a read the pointer steps after each byte across the whole array and rolls over from the top address to 0. A master NACK ends the read and releases the data line.
- R11: The pull-low enable changes only while the clock line is low. It never changes while the clock is high during a data or acknowledge bit.
- R12: A START that arrives before the STOP of a write discards the buffered data. Nothing is committed and no busy period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen at the pad |
| strap_i | input | 3 | Device address straps; tie unused straps to 0 |
| wp_i | input | 1 | Write protect, high blocks every array write |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the data line |

## Verification
The protocol state and the pointer can only be seen through the acknowledge bits and the bytes read back. A wrong state shows up at the next acknowledge slot as a missing or extra pull-low. A wrong pointer or page offset shows up on the first byte read after the write. A wrong busy counter or commit sequencer shows up as a select answered too early or too late, or as a page read back with stale or misplaced bytes. Timing faults in the line driver show up as the pull-low enable moving while the clock is high, checked on every bit.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int PAGE_W = 6;
  localparam logic [3:0] SEL_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } eep_state_e;

  // upper seven bits of a select byte against the straps
  function automatic logic sel_match(input logic [6:0] id, input logic [2:0] strap);
    return id == {SEL_PREFIX, strap};
  endfunction

  // 15-bit word address from the two address bytes (top bit already dropped)
  function automatic logic [14:0] fold_addr(input logic [6:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[1];
  assign sda_lvl  = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_ev = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_ev  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int DW = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int N = 1 << PW;
  logic [DW-1:0] ent [N];
  logic          vld [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && widx == PW'(e)) ent[e] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    vld[e] <= 1'b0;
      else if (clr)                  vld[e] <= 1'b0;
      else if (we && widx == PW'(e)) vld[e] <= 1'b1;
    end
  end

  assign rdata  = ent[ridx];
  assign rvalid = vld[ridx];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave #(
  parameter int MEM_AW    = 11,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  import eep_pkg::*;

  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int PAGE_N = MEM_AW - PAGE_W;

  // bus events
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  // protocol state
  eep_state_e        st;
  logic [3:0]        bcnt;
  logic              in_ack, ack_drv, rw, mack, pend;
  logic [7:0]        shreg, rd_sh;
  logic [6:0]        ahi;
  logic [MEM_AW-1:0] ptr;

  // write cycle state
  logic [CNT_W-1:0]  busy_cnt;
  logic              busy, cmt_active;
  logic [PAGE_W-1:0] cmt_idx;
  logic [PAGE_N-1:0] cmt_page;

  // named internal events
  logic byte_done, sel_ok, commit_go, buf_clr, buf_we, mem_we;
  logic [7:0] buf_rdata, rd_data;
  logic buf_rvalid;

  assign busy      = busy_cnt != '0;
  assign byte_done = (st != ST_IDLE) && scl_fall && !in_ack && bcnt == 4'd8
                     && !start_ev && !stop_ev;
  assign sel_ok    = sel_match(shreg[7:1], strap_i) && !busy;
  assign commit_go = stop_ev && st == ST_WR && pend && !wp_i;
  assign buf_clr   = byte_done && st == ST_ALO;
  assign buf_we    = byte_done && st == ST_WR;
  assign mem_we    = cmt_active && buf_rvalid;

  eep_page_buf #(.DW(8), .PW(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .widx(ptr[PAGE_W-1:0]), .wdata(shreg), .ridx(cmt_idx),
    .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  eep_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr({cmt_page, cmt_idx}), .wdata(buf_rdata),
    .raddr(ptr), .rdata(rd_data)
  );

  // byte-level protocol engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      pend    <= 1'b0;
      shreg   <= '0;
      rd_sh   <= 8'hFF;
      ahi     <= '0;
      ptr     <= '0;
    end else if (start_ev) begin
      st      <= ST_DEV;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      pend    <= 1'b0;
    end else if (stop_ev) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      pend    <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (!in_ack) begin
          shreg <= {shreg[6:0], sda_lvl};
          bcnt  <= bcnt + 4'd1;
        end else begin
          mack <= !sda_lvl;
        end
      end
      if (byte_done) begin
        in_ack <= 1'b1;
        case (st)
          ST_DEV: begin
            if (sel_ok) begin
              ack_drv <= 1'b1;
              rw      <= shreg[0];
            end else begin
              st     <= ST_IDLE;
              in_ack <= 1'b0;
            end
          end
          ST_AHI: begin
            ack_drv <= 1'b1;
            ahi     <= shreg[6:0];
          end
          ST_ALO: begin
            ack_drv <= 1'b1;
            ptr     <= MEM_AW'(fold_addr(ahi, shreg));
          end
          ST_WR: begin
            ack_drv <= 1'b1;
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            pend    <= 1'b1;
          end
          default: ack_drv <= 1'b0;
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        bcnt    <= '0;
        ack_drv <= 1'b0;
        case (st)
          ST_DEV: begin
            if (rw) begin
              rd_sh <= rd_data;
              ptr   <= ptr + 1'b1;
              st    <= ST_RD;
            end else begin
              st <= ST_AHI;
            end
          end
          ST_AHI: st <= ST_ALO;
          ST_ALO: st <= ST_WR;
          ST_RD: begin
            if (mack) begin
              rd_sh <= rd_data;
              ptr   <= ptr + 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end else if (scl_fall && st == ST_RD && bcnt != 4'd0) begin
        rd_sh <= {rd_sh[6:0], 1'b1};
      end
    end
  end

  // self-timed write cycle: one buffer entry per clock into the array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      cmt_active <= 1'b0;
      cmt_idx    <= '0;
      cmt_page   <= '0;
    end else if (commit_go) begin
      busy_cnt   <= CNT_W'(WR_CYCLES);
      cmt_active <= 1'b1;
      cmt_idx    <= '0;
      cmt_page   <= ptr[MEM_AW-1:PAGE_W];
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cmt_active) begin
        cmt_idx <= cmt_idx + 1'b1;
        if (&cmt_idx) cmt_active <= 1'b0;
      end
    end
  end

  assign sda_pull_o = ack_drv | (st == ST_RD && !in_ack && !rd_sh[7]);
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic stop_ev,
  input logic wp_i,
  input logic busy,
  input logic mem_we,
  input logic sda_pull_o
);
  // R5: nothing is acknowledged while the write cycle runs
  assert_quiet_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // R4: the array is written only inside the busy period
  assert_commit_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7: a busy period starts only from a STOP with write-protect low
  assert_busy_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_ev) && !$past(wp_i)));

  // R11: the pull-low is applied only while the clock is low
  assert_pull_on_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_lvl));
endmodule

bind eep2w_slave eep_checker u_eep_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_ev(stop_ev), .wp_i(wp_i),
  .busy(busy), .mem_we(mem_we), .sda_pull_o(sda_pull_o)
);

// File: tb/test_eep2w_slave.sv
module test_eep2w_slave;
  localparam int AW  = 11;
  localparam int WRC = 1500;
  localparam int Q   = 6;
  localparam int MSK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  wire  sda_pull;
  wire  sda_line = m_sda & ~sda_pull;

  eep2w_slave #(.MEM_AW(AW), .WR_CYCLES(WRC)) i_eep2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] bmem  [0:MSK];
  bit         bknow [0:MSK];
  logic [7:0] wbuf  [0:127];
  logic [7:0] rbuf  [0:127];

  function automatic int fold(input logic [15:0] a);
    return int'(a) & 32'h7FFF & MSK;
  endfunction
  function automatic int page_step(input int a);
    return (a & ~63) | ((a + 1) & 63);
  endfunction
  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; wq; m_scl = 1; wq; m_sda = 0; wq; m_scl = 0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 0; wq; m_scl = 1; wq; m_sda = 1; wq;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; m_scl = 1; wq(2); m_scl = 0; wq;
    end
    m_sda = 1; wq; m_scl = 1; wq;
    ack = !sda_line;
    wq; m_scl = 0; wq;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    logic p0;
    int moved;
    moved = 0;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; m_scl = 1; wq;
      b[i] = sda_line; p0 = sda_pull;
      wq;
      if (sda_pull !== p0) moved++;
      m_scl = 0;
    end
    chk("R11 pull stable while clock high", moved, 0);
    wq; m_sda = !give_ack; wq; m_scl = 1; wq(2); m_scl = 0; wq; m_sda = 1;
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input bit commit, input bit do_stop);
    bit ack;
    int cur;
    bus_start;
    put_byte(sel(0), ack);   chk("R2 select ack on write", ack, 1);
    put_byte(a[15:8], ack);  chk("R3 high address ack", ack, 1);
    put_byte(a[7:0], ack);   chk("R3 low address ack", ack, 1);
    cur = fold(a);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], ack);
      chk("R4 data byte ack", ack, 1);
      if (commit) begin
        bmem[cur] = wbuf[k];
        bknow[cur] = 1;
      end
      cur = page_step(cur);
    end
    if (do_stop) bus_stop;
  endtask

  task automatic read_at(input logic [15:0] a, input int n);
    bit ack;
    bus_start;
    put_byte(sel(0), ack);  chk("R8 dummy write select", ack, 1);
    put_byte(a[15:8], ack);
    put_byte(a[7:0], ack);
    bus_start;
    put_byte(sel(1), ack);  chk("R8 read select ack", ack, 1);
    for (int k = 0; k < n; k++) get_byte(k != n - 1, rbuf[k]);
    bus_stop;
  endtask

  task automatic read_cur(input int n);
    bit ack;
    bus_start;
    put_byte(sel(1), ack);  chk("R9 current read select", ack, 1);
    for (int k = 0; k < n; k++) get_byte(k != n - 1, rbuf[k]);
    bus_stop;
  endtask

  task automatic select_probe(input string req, input int exp);
    bit ack;
    bus_start;
    put_byte(sel(0), ack);
    chk(req, ack, exp);
    bus_stop;
  endtask

  task automatic wait_wr;
    repeat (WRC + 50) @(negedge clk);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    int a, n;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i <= MSK; i++) bknow[i] = 0;

    // R1: reset state
    repeat (8) @(negedge clk);
    chk("R1 pull idle in reset", sda_pull, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    chk("R1 pull idle after reset", sda_pull, 0);
    select_probe("R1 first select acked", 1);

    // R2: strap mismatch, prefix mismatch, bus ignored afterwards
    bus_start;
    put_byte({4'b1010, 3'b011, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 0);
    put_byte(8'h00, ack);                   chk("R2 ignored until START", ack, 0);
    bus_stop;
    bus_start;
    put_byte({4'b1011, strap, 1'b0}, ack);  chk("R2 prefix mismatch nack", ack, 0);
    bus_stop;

    // R4 / R5: byte write, busy window, then read back
    wbuf[0] = 8'hA5;
    write_seq(16'h0123, 1, 1, 1);
    select_probe("R5 select nacked while busy", 0);
    repeat (WRC) @(negedge clk);
    select_probe("R5 select acked after busy", 1);
    read_at(16'h0123, 1);
    chk("R4 byte write stored", rbuf[0], bmem[16'h123]);

    // R3: ignored upper address bits
    wbuf[0] = 8'($urandom); wbuf[1] = 8'($urandom);
    write_seq(16'hF940, 2, 1, 1);
    wait_wr;
    read_at(16'h0140, 1);
    chk("R3 upper address bits ignored", rbuf[0], bmem[16'h140]);

    // R9: current-address read continues after the last byte read
    read_cur(1);
    chk("R9 current address read", rbuf[0], bmem[16'h141]);

    // R6: page write of 70 bytes from offset 60 wraps and overwrites
    for (int k = 0; k < 70; k++) wbuf[k] = 8'($urandom);
    write_seq(16'h023C, 70, 1, 1);
    wait_wr;
    read_at(16'h0200, 64);
    for (int k = 0; k < 64; k++) chk("R6 page wrap content", rbuf[k], bmem[16'h200 + k]);

    // constrained random writes and sequential read-back (R4, R10)
    for (int it = 0; it < 6; it++) begin
      a = int'($urandom) & MSK;
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_seq(16'(a), n, 1, 1);
      wait_wr;
      read_at(16'(a), n);
      for (int k = 0; k < n; k++)
        if (bknow[(a + k) & MSK]) chk("R10 sequential read-back", rbuf[k], bmem[(a + k) & MSK]);
    end

    // R7: write protect blocks commit and busy
    wp = 1;
    for (int k = 0; k < 3; k++) wbuf[k] = ~bmem[16'h123 + k];
    write_seq(16'h0123, 3, 0, 1);
    select_probe("R7 no busy under write protect", 1);
    wp = 0;
    read_at(16'h0123, 1);
    chk("R7 array unchanged under write protect", rbuf[0], bmem[16'h123]);

    // R10: roll over from top address to zero, NACK releases the line
    wbuf[0] = 8'h3C; write_seq(16'(MSK), 1, 1, 1); wait_wr;
    wbuf[0] = 8'hC3; write_seq(16'h0000, 1, 1, 1); wait_wr;
    read_at(16'(MSK), 2);
    chk("R10 top address byte", rbuf[0], bmem[MSK]);
    chk("R10 rollover to zero", rbuf[1], bmem[0]);
    chk("R10 line released after NACK", sda_pull, 0);

    // R12: repeated START aborts a pending write
    wbuf[0] = ~bmem[16'h123];
    write_seq(16'h0123, 1, 0, 0);
    bus_start;
    bus_stop;
    select_probe("R12 no busy after aborted write", 1);
    read_at(16'h0123, 1);
    chk("R12 aborted write not committed", rbuf[0], bmem[16'h123]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule